// File: doc/BRIEF.md
# Link Negotiation Session Starter and Mode Resolver

This block is the control part of a twisted-pair link negotiation unit. It decides when a new negotiation session has to begin and, when the exchange logic reports that the session is over, picks the best operating mode that both ends support. The pulse exchange itself and the register bus are outside the block. The register bus drives the restart write strobe and the local ability vector. The exchange logic receives the start pulse and returns the completion flag.

A session can be started by four events: the end of chip reset, a soft reset, the link going down, and a write of one to the restart control bit. Each of them counts only while negotiation is enabled. When the session completes, the resolver ANDs the local and partner ability vectors. It then picks the fastest, full-duplex-first mode from the result and shows it as speed and duplex indication bits. If the two vectors have no ability in common, it raises a flag instead.

Top module: `an_start_resolve`

## Requirements
- R1: After chip reset (`rst_n` low) is released with `neg_en` high, `start_pulse` is high for exactly the first clock cycle after the first rising edge. `neg_busy` rises at the same edge.
- R2: A clock edge that samples `soft_rst` high while `neg_en` is high makes `start_pulse` and `neg_busy` high after that edge.
- R3: A clock edge at which `link_up` is low, after being sampled high at the previous edge, starts a session in the same way. A rise of `link_up` starts nothing.
- R4: A write strobe `restart_wr` sets `restart_bit` at the next edge. While `neg_en` is high, the following edge issues `start_pulse` and clears `restart_bit`.
- R5: While `neg_en` is low, no trigger produces `start_pulse`. A pending `restart_bit` stays set until negotiation is enabled, and then it starts a session.
- R6: Chip reset clears all outputs: `start_pulse`, `neg_busy`, `restart_bit`, `spd_100`, `full_dup` and `no_common` all read 0.
- R7: `neg_busy` stays high from the start edge until an edge that samples `xchg_done` high. A `xchg_done` seen while `neg_busy` is low changes no output.
- R8: On completion, the result is chosen from `loc_abil & lp_abil` with bit 3 = 100M full, bit 2 = 100M half, bit 1 = 10M full and bit 0 = 10M half. The highest set bit wins, and the outputs become `{spd_100, full_dup}` = 11, 10, 01 or 00 respectively.
- R9: A completion with no common ability sets `no_common` and leaves `spd_100` and `full_dup` unchanged. A later completion that does find a common ability clears `no_common`.
- R10: While `neg_busy` is high and `xchg_done` is low, `spd_100` and `full_dup` hold their values, whatever the ability inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Chip reset, active low, asynchronous |
| soft_rst | input | 1 | Soft reset trigger |
| link_up | input | 1 | Link status, high when the link is up |
| restart_wr | input | 1 | Write strobe setting the restart bit |
| neg_en | input | 1 | Negotiation enable |
| loc_abil | input | 4 | Local advertised abilities (R8 encoding) |
| lp_abil | input | 4 | Link partner abilities (R8 encoding) |
| xchg_done | input | 1 | Session completion flag from the exchange logic |
| start_pulse | output | 1 | One-cycle start request to the burst logic |
| neg_busy | output | 1 | Negotiation in progress |
| spd_100 | output | 1 | Resolved speed, 1 = 100M |
| full_dup | output | 1 | Resolved duplex, 1 = full |
| restart_bit | output | 1 | Restart control bit, clears itself |
| no_common | output | 1 | Last completion found no common ability |

## Verification
The hardest situations to reach are those where triggers overlap with completion or with a disabled block. Examples are a restart written while `neg_en` is low and then released, a link drop in the same cycle as `xchg_done`, and a no-common completion that must keep an older result. Directed phases set up each of these on purpose: the restart-while-disabled case, a no-common completion after a valid result, and ability changes during a busy session. A long random phase then drives sparse triggers and completions against a behavioural model, so that the coincident cases occur as well.

// File: rtl/an_start_resolve.sv
module an_start_resolve #(
  parameter int ABIL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              link_up,
  input  logic              restart_wr,
  input  logic              neg_en,
  input  logic [ABIL_W-1:0] loc_abil,
  input  logic [ABIL_W-1:0] lp_abil,
  input  logic              xchg_done,
  output logic              start_pulse,
  output logic              neg_busy,
  output logic              spd_100,
  output logic              full_dup,
  output logic              restart_bit,
  output logic              no_common
);

  logic              por_pend;
  logic              link_q;
  logic [ABIL_W-1:0] common;
  logic              trig, go, finish;
  logic              res_spd, res_fd;

  assign common = loc_abil & lp_abil;
  assign trig   = por_pend | soft_rst | (link_q & ~link_up) | restart_bit;
  assign go     = neg_en & trig;
  assign finish = neg_busy & xchg_done;

  always_comb begin
    res_spd = spd_100;
    res_fd  = full_dup;
    if (common[3])      begin res_spd = 1'b1; res_fd = 1'b1; end
    else if (common[2]) begin res_spd = 1'b1; res_fd = 1'b0; end
    else if (common[1]) begin res_spd = 1'b0; res_fd = 1'b1; end
    else if (common[0]) begin res_spd = 1'b0; res_fd = 1'b0; end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_pend    <= 1'b1;
      link_q      <= 1'b0;
      start_pulse <= 1'b0;
      neg_busy    <= 1'b0;
      restart_bit <= 1'b0;
      spd_100     <= 1'b0;
      full_dup    <= 1'b0;
      no_common   <= 1'b0;
    end else begin
      por_pend    <= 1'b0;
      link_q      <= link_up;
      start_pulse <= go;
      neg_busy    <= go | (neg_busy & ~xchg_done);
      restart_bit <= restart_wr | (restart_bit & ~go);
      if (finish) begin
        spd_100   <= res_spd;
        full_dup  <= res_fd;
        no_common <= ~|common;
      end
    end
  end

  p_soft_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (neg_en && soft_rst) |=> (start_pulse && neg_busy));

  p_restart_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_bit && neg_en && !restart_wr) |=> !restart_bit);

  p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !neg_en |=> !start_pulse);

  p_top_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (neg_busy && xchg_done && loc_abil[3] && lp_abil[3]) |=> (spd_100 && full_dup));

  p_nomode_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (neg_busy && xchg_done && ((loc_abil & lp_abil) == '0))
      |=> (no_common && $stable({spd_100, full_dup})));

  p_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (neg_busy && !xchg_done) |=> $stable({spd_100, full_dup}));

endmodule

// File: tb/sim_an_start_resolve.sv
module sim_an_start_resolve;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 0, link_up = 0, restart_wr = 0, neg_en = 1, xchg_done = 0;
  logic [3:0] loc_abil = 4'hF, lp_abil = 4'h0;
  logic start_pulse, neg_busy, spd_100, full_dup, restart_bit, no_common;

  always #2.5 clk = ~clk;

  an_start_resolve u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .link_up(link_up),
    .restart_wr(restart_wr), .neg_en(neg_en), .loc_abil(loc_abil),
    .lp_abil(lp_abil), .xchg_done(xchg_done), .start_pulse(start_pulse),
    .neg_busy(neg_busy), .spd_100(spd_100), .full_dup(full_dup),
    .restart_bit(restart_bit), .no_common(no_common)
  );

  int vectors = 0;
  int errors  = 0;
  string req = "R6";
  bit m_por, m_lprev, m_rbit, m_st, m_busy, m_spd, m_fd, m_nc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_por = 1; m_lprev = 0; m_rbit = 0; m_st = 0;
      m_busy = 0; m_spd = 0; m_fd = 0; m_nc = 0;
    end else begin
      bit go;
      logic [3:0] c;
      go = neg_en && (m_por || soft_rst || (m_lprev && !link_up) || m_rbit);
      c = loc_abil & lp_abil;
      if (m_busy && xchg_done) begin
        if (c == 0) m_nc = 1;
        else begin
          m_nc = 0;
          m_spd = (c[3] || c[2]);
          m_fd  = c[3] ? 1'b1 : (c[2] ? 1'b0 : (c[1] ? 1'b1 : 1'b0));
        end
      end
      m_busy = go || (m_busy && !xchg_done);
      m_rbit = restart_wr || (m_rbit && !go);
      m_st = go;
      m_por = 0;
      m_lprev = link_up;
    end
  end

  task automatic cmp(string name, logic act, bit exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, name, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cmp("start_pulse", start_pulse, m_st);
    cmp("neg_busy", neg_busy, m_busy);
    cmp("spd_100", spd_100, m_spd);
    cmp("full_dup", full_dup, m_fd);
    cmp("restart_bit", restart_bit, m_rbit);
    cmp("no_common", no_common, m_nc);
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic pulse_done;
    xchg_done = 1; tick(); xchg_done = 0; tick();
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    req = "R6"; tick(3);
    req = "R1"; rst_n = 1; tick(4);
    req = "R9"; pulse_done(); tick(2);
    req = "R4"; lp_abil = 4'b0110; restart_wr = 1; tick(); restart_wr = 0; tick(4);
    req = "R8"; pulse_done(); tick(2);
    req = "R2"; lp_abil = 4'hF; soft_rst = 1; tick(); soft_rst = 0; tick(3);
    req = "R10"; loc_abil = 4'b0001; lp_abil = 4'b0001; tick(5);
    loc_abil = 4'hF; lp_abil = 4'hF; pulse_done();
    req = "R9"; soft_rst = 1; tick(); soft_rst = 0; lp_abil = 4'h0; tick(); pulse_done();
    req = "R3"; link_up = 1; tick(4); link_up = 0; tick(3);
    loc_abil = 4'b0011; lp_abil = 4'b0010; pulse_done();
    req = "R8"; link_up = 1; tick(2); link_up = 0; tick(2);
    loc_abil = 4'b0001; lp_abil = 4'b0001; pulse_done();
    req = "R7"; loc_abil = 4'hF; lp_abil = 4'hF; pulse_done(); tick(3);
    req = "R5"; neg_en = 0; soft_rst = 1; tick(); soft_rst = 0; tick();
    link_up = 1; tick(2); link_up = 0; tick(2);
    restart_wr = 1; tick(); restart_wr = 0; tick(5);
    neg_en = 1; tick(3); pulse_done();
    req = "R1"; neg_en = 0; rst_n = 0; tick(2); rst_n = 1; tick(4); neg_en = 1; tick(2);
    rst_n = 0; tick(); rst_n = 1; tick(3); pulse_done();
    req = "R8";
    for (int i = 0; i < 3000; i++) begin
      soft_rst   = ($urandom_range(0, 40) == 0);
      restart_wr = ($urandom_range(0, 40) == 0);
      xchg_done  = ($urandom_range(0, 6) == 0);
      neg_en     = ($urandom_range(0, 15) != 0);
      if ($urandom_range(0, 20) == 0) link_up = ~link_up;
      if ($urandom_range(0, 8) == 0) begin
        loc_abil = 4'($urandom_range(0, 15));
        lp_abil  = 4'($urandom_range(0, 15));
      end
      tick();
    end
    soft_rst = 0; restart_wr = 0; xchg_done = 0;
    tick(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule